// File: doc/BRIEF.md
# Conversion step sequencer controller

This block decides when a converter starts and stops, and which of up to 32 configuration steps it uses. Software-side write strobes arrive for the control register (start, stop, first step), for the sequencer configuration register (operating mode) and for the step-enable mask. A fixed-latency timer inside the block stands in for the converter. Each time a conversion completes, the block issues a one-cycle result strobe. With that strobe it publishes three tags for the result: the step the result belongs to, a 4-bit conversion counter and a 4-bit run counter.

There are four modes. Mode 00 makes one conversion per start. Mode 01 converts until a stop. Mode 10 walks the enabled steps in ascending order once. Mode 11 walks them repeatedly and counts the passes. A powerdown input aborts any activity and clears the tags. A write to the mode register also clears the tags. The synchronous reset restores every register.

Top module: `conv_seq_ctrl`

## Requirements
- R1: After reset, busy and stop_pending are 0, step_ind is 0, conv_cnt is 15 and run_cnt is 0. The mode is 01 and only step 0 is enabled (mask bit i enables step i).
- R2: In mode 00, a start gives exactly one result, tagged with the first-step field of the start write, and then busy returns to 0.
- R3: In mode 01, conversions repeat until a stop write. A stop lets the conversion in progress finish and produce its result. stop_pending is 1 only while busy, and it is 0 again once busy drops.
- R4: A control write with both start and stop set changes nothing: busy stays as it was and no result is produced.
- R5: A start while busy aborts the conversion in progress and restarts it. The next result arrives CONV_CYCLES+1 cycles after the restarting write, and the aborted conversion gives no result.
- R6: conv_cnt preloads to 15. It adds 1 on every result and wraps from 15 to 0, so the first result reads 0. In modes 00 and 01 it does not restart when the step changes.
- R7: In modes 10 and 11, each step performs STEP_CONVS conversions. conv_cnt reads 0 on the first result of every step and counts up within the step.
- R8: The sequencer visits enabled steps in ascending order and skips disabled ones. In mode 10 it goes idle after the highest enabled step.
- R9: A start in mode 10 or 11 begins at the lowest enabled step at or above the first-step field. If there is none, it begins at the lowest enabled step.
- R10: In mode 11, after the highest enabled step the sequencer continues at the lowest enabled step. run_cnt rises by 1 on the first result of each new pass and wraps after 15. A stop in mode 11 ends activity at the end of the current pass.
- R11: run_cnt reads 0 at every result in modes 00, 01 and 10. In mode 11, the first result after a start reads 0.
- R12: A mode write or powerdown clears the tags (step_ind 0, conv_cnt 15, run_cnt 0) on the next cycle. Powerdown also clears busy. A start is ignored while powerdown is high.
- R13: With the mask all zero, a start in mode 10 or 11 produces no result and leaves busy at 0.
- R14: step_ind is the step of the most recent result and holds that value after the block goes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwdn | input | 1 | Powerdown level: aborts activity and clears the tags |
| ctrl_wr | input | 1 | Control register write strobe |
| wr_start | input | 1 | Start bit of the control write |
| wr_stop | input | 1 | Stop bit of the control write |
| wr_first_step | input | 5 | First-step field of the control write |
| mode_wr | input | 1 | Mode register write strobe (clears the tags) |
| wr_mode | input | 2 | Mode value: 00 single, 01 continuous, 10 one pass, 11 looping |
| mask_wr | input | 1 | Step-enable mask write strobe |
| wr_mask | input | 32 | Step-enable mask, bit i enables step i |
| busy | output | 1 | Conversions in progress |
| active_step | output | 5 | Step of the conversion currently running |
| stop_pending | output | 1 | A stop has been accepted and is waiting to take effect |
| res_valid | output | 1 | One-cycle strobe: a result completed and the tags are updated |
| step_ind | output | 5 | Step tag of the latest result |
| conv_cnt | output | 4 | Conversion counter tag |
| run_cnt | output | 4 | Run counter tag |

## Verification
Several rules are checked by assertions on every cycle: the timer's completion strobe lasts one cycle, a pending stop never exists while idle, results only follow a busy cycle, run_cnt stays 0 outside mode 11, and the tags are cleared after powerdown. The same checks cover the no-op start-and-stop write and an empty-mask start that stays idle. Other behaviour needs an ordered series of events, so only the bench scenarios can show it: the order in which steps are visited, where a start with the first-step field lands, the wrap of both counters, how many results follow a stop, and when a restarted conversion completes.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
    localparam int unsigned NSTEP  = 32;
    localparam int unsigned STEP_W = $clog2(NSTEP);
    localparam int unsigned TAG_W  = 4;

    typedef logic [STEP_W-1:0] step_t;
    typedef logic [TAG_W-1:0]  tag_t;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'b00,
        MODE_CONT   = 2'b01,
        MODE_PASS   = 2'b10,
        MODE_LOOP   = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        RUN_KEEP = 2'b00,
        RUN_ZERO = 2'b01,
        RUN_INC  = 2'b10
    } run_op_e;

    typedef struct packed {
        step_t step;
        tag_t  conv;
        tag_t  run;
    } tags_t;

    function automatic logic seq_on(input mode_e m);
        return m[1];
    endfunction
endpackage

// File: rtl/conv_step_pick.sv
module conv_step_pick #(
    parameter int unsigned N = 32,
    parameter int unsigned W = $clog2(N)
) (
    input  logic [N-1:0] mask,
    input  logic [W:0]   lo,
    output logic         found,
    output logic [W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i] && (i >= int'(lo))) begin
                found = 1'b1;
                idx   = W'(i);
            end
        end
    end
endmodule

// File: rtl/conv_timer.sv
module conv_timer #(
    parameter int unsigned LAT = 4,
    parameter int unsigned CW  = $clog2(LAT + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  logic kill,
    output logic done
);
    logic [CW-1:0] cnt;
    logic          run;

    always_ff @(posedge clk) begin
        if (rst || kill) begin
            run  <= 1'b0;
            cnt  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                run <= 1'b1;
                cnt <= CW'(LAT - 1);
            end else if (run) begin
                if (cnt == '0) begin
                    done <= 1'b1;
                    run  <= 1'b0;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/conv_tags.sv
module conv_tags
    import conv_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    clr,
    input  logic    upd,
    input  mode_e   mode,
    input  logic    first_of_step,
    input  run_op_e run_op,
    input  step_t   step_in,
    output tags_t   tags,
    output logic    res_valid
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            tags.step <= '0;
            tags.conv <= '1;
            tags.run  <= '0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= upd;
            if (upd) begin
                tags.step <= step_in;
                tags.conv <= (seq_on(mode) && first_of_step) ? '0 : tags.conv + 1'b1;
                if (mode != MODE_LOOP) begin
                    tags.run <= '0;
                end else begin
                    case (run_op)
                        RUN_ZERO: tags.run <= '0;
                        RUN_INC:  tags.run <= tags.run + 1'b1;
                        default:  tags.run <= tags.run;
                    endcase
                end
            end
        end
    end

    // R11
    run_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (tags.run != '0) |-> (mode == MODE_LOOP));
endmodule

// File: rtl/conv_seq_ctrl.sv
module conv_seq_ctrl
    import conv_seq_pkg::*;
#(
    parameter int unsigned CONV_CYCLES = 4,
    parameter int unsigned STEP_CONVS  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwdn,
    input  logic              ctrl_wr,
    input  logic              wr_start,
    input  logic              wr_stop,
    input  logic [STEP_W-1:0] wr_first_step,
    input  logic              mode_wr,
    input  logic [1:0]        wr_mode,
    input  logic              mask_wr,
    input  logic [NSTEP-1:0]  wr_mask,
    output logic              busy,
    output logic [STEP_W-1:0] active_step,
    output logic              stop_pending,
    output logic              res_valid,
    output logic [STEP_W-1:0] step_ind,
    output logic [TAG_W-1:0]  conv_cnt,
    output logic [TAG_W-1:0]  run_cnt
);
    localparam int unsigned RW = (STEP_CONVS > 1) ? $clog2(STEP_CONVS) : 1;

    mode_e            mode_q;
    logic [NSTEP-1:0] mask_q;
    logic             busy_q, busy_d;
    step_t            step_q, step_d;
    logic [RW-1:0]    rep_q, rep_d;
    logic             stop_q, stop_d;
    run_op_e          run_q, run_d;

    logic  go, kill, conv_done, tag_upd;
    logic  start_cmd, stop_cmd, stop_now, seq, last_rep, start_empty;
    logic  init_found, low_found, next_found;
    step_t init_idx, low_idx, next_idx;
    tags_t tags;

    assign start_cmd   = ctrl_wr && wr_start && !wr_stop && !pwdn;
    assign stop_cmd    = ctrl_wr && wr_stop && !wr_start;
    assign stop_now    = stop_q || stop_cmd;
    assign seq         = seq_on(mode_q);
    assign last_rep    = (rep_q == RW'(STEP_CONVS - 1));
    assign start_empty = start_cmd && seq && !low_found;
    assign kill        = pwdn || start_empty;

    conv_step_pick #(.N(NSTEP), .W(STEP_W)) u_pick_init (
        .mask(mask_q), .lo({1'b0, wr_first_step}), .found(init_found), .idx(init_idx));
    conv_step_pick #(.N(NSTEP), .W(STEP_W)) u_pick_low (
        .mask(mask_q), .lo('0), .found(low_found), .idx(low_idx));
    conv_step_pick #(.N(NSTEP), .W(STEP_W)) u_pick_next (
        .mask(mask_q), .lo({1'b0, step_q} + (STEP_W + 1)'(1)), .found(next_found), .idx(next_idx));

    conv_timer #(.LAT(CONV_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .go(go), .kill(kill), .done(conv_done));

    always_comb begin
        busy_d  = busy_q;
        step_d  = step_q;
        rep_d   = rep_q;
        stop_d  = stop_q;
        run_d   = run_q;
        go      = 1'b0;
        tag_upd = 1'b0;
        if (pwdn) begin
            busy_d = 1'b0;
            stop_d = 1'b0;
            rep_d  = '0;
            run_d  = RUN_KEEP;
        end else if (start_cmd) begin
            stop_d = 1'b0;
            rep_d  = '0;
            run_d  = RUN_ZERO;
            if (!seq) begin
                busy_d = 1'b1;
                step_d = wr_first_step;
                go     = 1'b1;
            end else if (!low_found) begin
                busy_d = 1'b0;
            end else begin
                busy_d = 1'b1;
                step_d = init_found ? init_idx : low_idx;
                go     = 1'b1;
            end
        end else if (conv_done && busy_q) begin
            tag_upd = 1'b1;
            run_d   = RUN_KEEP;
            case (mode_q)
                MODE_SINGLE: begin
                    busy_d = 1'b0;
                    stop_d = 1'b0;
                end
                MODE_CONT: begin
                    if (stop_now) begin
                        busy_d = 1'b0;
                        stop_d = 1'b0;
                    end else begin
                        go = 1'b1;
                    end
                end
                default: begin
                    if (!last_rep) begin
                        rep_d  = rep_q + 1'b1;
                        stop_d = stop_now;
                        go     = 1'b1;
                    end else if (next_found) begin
                        step_d = next_idx;
                        rep_d  = '0;
                        stop_d = stop_now;
                        go     = 1'b1;
                    end else if (mode_q == MODE_LOOP && !stop_now && low_found) begin
                        step_d = low_idx;
                        rep_d  = '0;
                        run_d  = RUN_INC;
                        go     = 1'b1;
                    end else begin
                        busy_d = 1'b0;
                        stop_d = 1'b0;
                        rep_d  = '0;
                    end
                end
            endcase
        end else if (stop_cmd && busy_q) begin
            stop_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_CONT;
            mask_q <= NSTEP'(1);
            busy_q <= 1'b0;
            step_q <= '0;
            rep_q  <= '0;
            stop_q <= 1'b0;
            run_q  <= RUN_KEEP;
        end else begin
            if (mode_wr) mode_q <= mode_e'(wr_mode);
            if (mask_wr) mask_q <= wr_mask;
            busy_q <= busy_d;
            step_q <= step_d;
            rep_q  <= rep_d;
            stop_q <= stop_d;
            run_q  <= run_d;
        end
    end

    conv_tags u_tags (
        .clk(clk), .rst(rst), .clr(pwdn || mode_wr), .upd(tag_upd), .mode(mode_q),
        .first_of_step(rep_q == '0), .run_op(run_q), .step_in(step_q),
        .tags(tags), .res_valid(res_valid));

    assign busy         = busy_q;
    assign active_step  = step_q;
    assign stop_pending = stop_q;
    assign step_ind     = tags.step;
    assign conv_cnt     = tags.conv;
    assign run_cnt      = tags.run;

    // R12
    pwdn_clear_chk: assert property (@(posedge clk) disable iff (rst)
        pwdn |=> (!busy && step_ind == '0 && conv_cnt == '1 && run_cnt == '0));

    // R4
    both_nop_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && wr_start && wr_stop && !pwdn && !conv_done) |=>
            ($stable(busy) && $stable(active_step) && !res_valid));

    // R3
    stop_busy_chk: assert property (@(posedge clk) disable iff (rst)
        stop_pending |-> busy);

    // R2
    res_busy_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(busy));

    // R13
    empty_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && wr_start && !wr_stop && !pwdn && mode_q[1] && mask_q == '0) |=> !busy);
endmodule

// File: tb/conv_seq_ctrl_test.sv
`timescale 1ns/1ps
module conv_seq_ctrl_test;
    localparam int LAT  = 4;
    localparam int REPS = 2;

    typedef struct packed {
        logic [1:0]  mode;
        logic [31:0] mask;
        logic [4:0]  first;
        logic [7:0]  n;
        logic [4:0]  step_a;
        logic [4:0]  step_z;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{2'b00, 32'h0000_0001, 5'd5,  8'd1, 5'd5,  5'd5},
        '{2'b10, 32'h0000_0013, 5'd0,  8'd6, 5'd0,  5'd4},
        '{2'b10, 32'h8000_0100, 5'd9,  8'd2, 5'd31, 5'd31},
        '{2'b10, 32'h0000_0024, 5'd6,  8'd4, 5'd2,  5'd5},
        '{2'b10, 32'h0000_0001, 5'd0,  8'd2, 5'd0,  5'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pwdn = 1'b0;
    logic        ctrl_wr = 1'b0, wr_start = 1'b0, wr_stop = 1'b0;
    logic [4:0]  wr_first_step = '0;
    logic        mode_wr = 1'b0;
    logic [1:0]  wr_mode = '0;
    logic        mask_wr = 1'b0;
    logic [31:0] wr_mask = '0;
    logic        busy, stop_pending, res_valid;
    logic [4:0]  active_step, step_ind;
    logic [3:0]  conv_cnt, run_cnt;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    conv_seq_ctrl #(.CONV_CYCLES(LAT), .STEP_CONVS(REPS)) uut (
        .clk(clk), .rst(rst), .pwdn(pwdn), .ctrl_wr(ctrl_wr), .wr_start(wr_start),
        .wr_stop(wr_stop), .wr_first_step(wr_first_step), .mode_wr(mode_wr),
        .wr_mode(wr_mode), .mask_wr(mask_wr), .wr_mask(wr_mask), .busy(busy),
        .active_step(active_step), .stop_pending(stop_pending), .res_valid(res_valid),
        .step_ind(step_ind), .conv_cnt(conv_cnt), .run_cnt(run_cnt));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_ctrl(input logic s, input logic p, input logic [4:0] f);
        @(negedge clk);
        ctrl_wr = 1'b1; wr_start = s; wr_stop = p; wr_first_step = f;
        @(negedge clk);
        ctrl_wr = 1'b0; wr_start = 1'b0; wr_stop = 1'b0;
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        mode_wr = 1'b1; wr_mode = m;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    task automatic set_mask(input logic [31:0] m);
        @(negedge clk);
        mask_wr = 1'b1; wr_mask = m;
        @(negedge clk);
        mask_wr = 1'b0;
    endtask

    task automatic wait_res(output bit got);
        got = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (res_valid) begin
                got = 1;
                break;
            end
        end
    endtask

    task automatic quiet(input int cyc, output int seen);
        seen = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (res_valid) seen++;
        end
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        bit got;
        int seen;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 stop_pending", stop_pending, 0);
        chk("R1 step_ind", step_ind, 0);
        chk("R1 conv_cnt", conv_cnt, 15);
        chk("R1 run_cnt", run_cnt, 0);

        // R1 default mode 01: continuous; R6 counting from 0
        do_ctrl(1'b1, 1'b0, 5'd0);
        for (int k = 0; k < 3; k++) begin
            wait_res(got);
            chk("R1 continuous result", got, 1);
            chk("R6 conv_cnt", conv_cnt, k);
        end
        chk("R1 still busy in mode 01", busy, 1);
        do_ctrl(1'b0, 1'b1, 5'd0);
        chk("R3 stop pending", stop_pending, 1);
        wait_res(got);
        chk("R3 final result", conv_cnt, 3);
        chk("R3 idle after stop", busy, 0);
        chk("R3 stop cleared", stop_pending, 0);
        quiet(LAT + 3, seen);
        chk("R3 no further result", seen, 0);

        // R1 default mask (step 0 only) with R9 fallback to lowest
        set_mode(2'b10);
        do_ctrl(1'b1, 1'b0, 5'd3);
        for (int k = 0; k < REPS; k++) begin
            wait_res(got);
            chk("R9 fallback step", step_ind, 0);
        end
        chk("R1 pass done", busy, 0);

        // Table walk: R2, R7, R8, R9, R14
        foreach (VECS[v]) begin
            set_mode(VECS[v].mode);
            set_mask(VECS[v].mask);
            do_ctrl(1'b1, 1'b0, VECS[v].first);
            for (int k = 0; k < int'(VECS[v].n); k++) begin
                wait_res(got);
                chk("R8 result arrives", got, 1);
                chk("R7 conv_cnt", conv_cnt, VECS[v].mode[1] ? (k % REPS) : k);
                chk("R11 run_cnt zero", run_cnt, 0);
                if (k == 0) chk("R9 first step", step_ind, VECS[v].step_a);
            end
            chk("R8 idle after pass", busy, 0);
            quiet(LAT + 3, seen);
            chk("R2 R8 result count", seen, 0);
            chk("R14 step held", step_ind, VECS[v].step_z);
        end

        // R4 start+stop together does nothing
        do_ctrl(1'b1, 1'b1, 5'd0);
        quiet(LAT + 3, seen);
        chk("R4 no result", seen, 0);
        chk("R4 still idle", busy, 0);

        // R5 restart while busy (mode 00)
        set_mode(2'b00);
        do_ctrl(1'b1, 1'b0, 5'd1);
        @(negedge clk);
        @(negedge clk);
        do_ctrl(1'b1, 1'b0, 5'd2);
        seen = 0;
        for (int i = 0; i < LAT; i++) begin
            @(negedge clk);
            if (res_valid) seen++;
        end
        chk("R5 no early result", seen, 0);
        @(negedge clk);
        chk("R5 result on time", res_valid, 1);
        chk("R5 restarted step", step_ind, 2);
        quiet(LAT + 3, seen);
        chk("R5 single result", seen, 0);

        // R6 wrap in mode 01
        set_mode(2'b01);
        do_ctrl(1'b1, 1'b0, 5'd4);
        for (int k = 0; k < 17; k++) begin
            wait_res(got);
            chk("R6 conv wrap", conv_cnt, k % 16);
        end
        do_ctrl(1'b0, 1'b1, 5'd0);
        wait_res(got);
        chk("R3 last conv", conv_cnt, 1);
        chk("R3 stopped", busy, 0);

        // R10 looping mode with run counter
        set_mode(2'b11);
        set_mask(32'h0000_000A);
        do_ctrl(1'b1, 1'b0, 5'd0);
        for (int k = 0; k < 69; k++) begin
            wait_res(got);
            chk("R10 step", step_ind, ((k % 4) < 2) ? 1 : 3);
            chk("R10 run_cnt", run_cnt, (k / 4) % 16);
            chk("R7 conv_cnt", conv_cnt, k % 2);
        end
        do_ctrl(1'b0, 1'b1, 5'd0);
        seen = 0;
        for (int k = 0; k < 3; k++) begin
            wait_res(got);
            if (got) seen++;
        end
        chk("R10 pass completes", seen, 3);
        chk("R10 idle after stop", busy, 0);
        chk("R10 run held", run_cnt, 1);

        // R11 start zeroes run counter
        do_ctrl(1'b1, 1'b0, 5'd0);
        wait_res(got);
        chk("R11 run after start", run_cnt, 0);

        // R12 mode write clears tags
        set_mode(2'b10);
        chk("R12 cfg step", step_ind, 0);
        chk("R12 cfg conv", conv_cnt, 15);
        chk("R12 cfg run", run_cnt, 0);
        for (int i = 0; i < 40 && busy; i++) @(negedge clk);
        chk("R12 drained", busy, 0);

        // R13 empty mask
        set_mask(32'h0);
        do_ctrl(1'b1, 1'b0, 5'd0);
        chk("R13 busy clear", busy, 0);
        quiet(LAT + 3, seen);
        chk("R13 no result", seen, 0);

        // R12 powerdown
        set_mode(2'b01);
        do_ctrl(1'b1, 1'b0, 5'd7);
        wait_res(got);
        wait_res(got);
        chk("R6 before pwdn", conv_cnt, 1);
        @(negedge clk);
        pwdn = 1'b1;
        @(negedge clk);
        chk("R12 pwdn busy", busy, 0);
        chk("R12 pwdn step", step_ind, 0);
        chk("R12 pwdn conv", conv_cnt, 15);
        do_ctrl(1'b1, 1'b0, 5'd7);
        quiet(LAT + 3, seen);
        chk("R12 start ignored", seen + int'(busy), 0);
        pwdn = 1'b0;

        // R1 reset mid-run
        do_ctrl(1'b1, 1'b0, 5'd2);
        wait_res(got);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset busy", busy, 0);
        chk("R1 reset step", step_ind, 0);
        chk("R1 reset conv", conv_cnt, 15);

        summary();
    end
endmodule